// File: doc/BRIEF.md
# Motion Activity/Inactivity Detector

This block watches a stream of signed three-axis acceleration samples, each accepted on a sample-valid strobe. From that stream it raises two kinds of single-cycle events. An activity event fires when any enabled axis moves past an activity threshold. An inactivity event fires when every enabled axis has stayed under an inactivity threshold for a programmed number of seconds, with the seconds counted from a one-second tick input. Each function has its own threshold and its own three axis enables. Each can also work in one of two ways: it compares the raw sample magnitude (dc coupling), or it compares the distance of the sample from a captured reference sample (ac coupling).

A link mode ties the two functions together so that they take turns: with both functions enabled, activity is only looked for once inactivity has been seen, and the reverse. On top of link mode, an auto-sleep flag is raised by inactivity and dropped by activity. A three-bit source field records which axes caused the latest activity event. Thresholds are 8-bit codes at sixteen sample LSBs per code. This matches 13-bit samples at about 4 mg per LSB against thresholds of 62.5 mg per code.

Top module: `motion_watch`

## Requirements
- R1: In dc activity mode, an enabled axis counts as over when |sample| > act_thr*16; a sample of exactly act_thr*16 does not count.
- R2: In ac activity mode, the first valid sample after reset, after each activity event, and after activity is armed in link mode is stored as the reference and raises no event. Later samples count as over when |sample − reference| > act_thr*16.
- R3: act_evt is a one-cycle pulse in the cycle after a valid sample on which at least one enabled axis is over. It never fires while act_axis_en is 0. Axis bit order is [0]=x, [1]=y, [2]=z for every axis field.
- R4: On each activity event, act_src is overwritten with the set of enabled axes that were over on that sample. It holds its value at all other times.
- R5: In dc inactivity mode, a valid sample is quiet when every enabled axis has |sample| < inact_thr*16. With inact_axis_en at 0, inactivity never fires.
- R6: A quiet run starts at a quiet sample and ends at any other valid sample. inact_evt pulses, one cycle after the sample, on the first quiet sample for which the sec_tick count since the run began has reached inact_time. A value of 0 fires on the first quiet sample. At most one event fires per run, and the tick count saturates at 255.
- R7: In ac inactivity mode, axes are compared as |sample − reference| < inact_thr*16. Any sample that is not quiet reloads the reference from itself. The first sample after reset or after re-arming only loads the reference and breaks the run.
- R8: With link_en set and both functions enabled, the detector starts by waiting for inactivity. After an inactivity event, only activity is looked for. After an activity event, only inactivity is looked for, with a fresh run and a fresh reference.
- R9: asleep sets on an inactivity event and clears on an activity event, but only while link_en and auto_sleep_en are both 1. Otherwise it is 0 one cycle later.
- R10: With link_en clear, or with either function disabled, the two functions run at the same time and do not affect each other.
- R11: After reset, act_evt, inact_evt, act_src and asleep are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe; the axis inputs are taken when it is 1 |
| smp_x | input | 13 | X sample, two's complement |
| smp_y | input | 13 | Y sample, two's complement |
| smp_z | input | 13 | Z sample, two's complement |
| sec_tick | input | 1 | One-cycle pulse each second |
| act_thr | input | 8 | Activity threshold code |
| inact_thr | input | 8 | Inactivity threshold code |
| inact_time | input | 8 | Inactivity time in seconds |
| act_ac | input | 1 | 1 = ac coupling for activity |
| inact_ac | input | 1 | 1 = ac coupling for inactivity |
| act_axis_en | input | 3 | Activity axis enables |
| inact_axis_en | input | 3 | Inactivity axis enables |
| link_en | input | 1 | Make the two functions take turns |
| auto_sleep_en | input | 1 | Drive asleep from events (needs link_en) |
| act_evt | output | 1 | Activity event pulse |
| inact_evt | output | 1 | Inactivity event pulse |
| act_src | output | 3 | Axes that caused the latest activity event |
| asleep | output | 1 | Auto-sleep indication |

## Verification
All four outputs come from registers. Their response to a sample or a tick accepted at a rising edge shows up right after that edge and is final one full cycle later. The bench changes inputs at the falling edge and steps its own model of the requirements at the same moment. At the next falling edge it compares act_evt, inact_evt, act_src and asleep against that model, so every check lands exactly one cycle after its stimulus. Timer runs, references and link phase are carried across samples only in the model's own state, never by reading the design.

// File: rtl/motion_pkg.sv
package motion_pkg;
  localparam int unsigned AXES      = 3;
  localparam int unsigned SMP_W     = 13;
  localparam int unsigned THR_W     = 8;
  localparam int unsigned THR_SHIFT = 4;
  localparam int unsigned TIME_W    = 8;

  // Magnitude of a signed value held in a 32-bit int
  function automatic int unsigned mag_of(input int signed v);
    return (v < 0) ? int'(-v) : int'(v);
  endfunction

  // Threshold code moved onto the sample LSB scale
  function automatic int unsigned thr_scaled(input int unsigned code, input int unsigned sh);
    return code << sh;
  endfunction
endpackage

// File: rtl/mw_axis_chan.sv
module mw_axis_chan
  import motion_pkg::*;
#(
  parameter int unsigned SW  = SMP_W,
  parameter int unsigned TW  = THR_W,
  parameter int unsigned SH  = THR_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [SW-1:0] smp,
  input  logic                 act_cap,
  input  logic                 inact_cap,
  input  logic                 act_ac,
  input  logic                 inact_ac,
  input  logic [TW-1:0]        act_thr,
  input  logic [TW-1:0]        inact_thr,
  output logic                 act_over,
  output logic                 inact_quiet
);
  logic signed [SW-1:0] act_ref_q;
  logic signed [SW-1:0] inact_ref_q;
  int unsigned          act_mag;
  int unsigned          inact_mag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ref_q   <= '0;
      inact_ref_q <= '0;
    end else begin
      if (act_cap)   act_ref_q   <= smp;
      if (inact_cap) inact_ref_q <= smp;
    end
  end

  always_comb begin
    act_mag   = mag_of(act_ac   ? (int'(smp) - int'(act_ref_q))   : int'(smp));
    inact_mag = mag_of(inact_ac ? (int'(smp) - int'(inact_ref_q)) : int'(smp));
    act_over    = act_mag   > thr_scaled(32'(act_thr), SH);
    inact_quiet = inact_mag < thr_scaled(32'(inact_thr), SH);
  end
endmodule

// File: rtl/mw_quiet_timer.sv
module mw_quiet_timer #(
  parameter int unsigned TIME_W = motion_pkg::TIME_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              quiet_smp,
  input  logic              break_smp,
  input  logic              restart,
  input  logic              tick,
  input  logic              fire,
  input  logic [TIME_W-1:0] time_lim,
  output logic              met
);
  localparam logic [TIME_W-1:0] CNT_MAX = '1;

  logic              run_q;
  logic              done_q;
  logic [TIME_W-1:0] cnt_q;

  always_comb begin
    met = quiet_smp && !done_q && (run_q ? (cnt_q >= time_lim) : (time_lim == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (restart || break_smp) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (quiet_smp && !run_q) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q && tick && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (fire) done_q <= 1'b1;
    end
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == CNT_MAX && !restart && !break_smp) |=> (cnt_q == CNT_MAX)); // R6

  AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !restart && !break_smp) |=> !fire || !quiet_smp || !met); // R6
endmodule

// File: rtl/mw_link_seq.sv
module mw_link_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic link_en,
  input  logic sleep_en,
  input  logic act_on,
  input  logic inact_on,
  input  logic act_fire,
  input  logic inact_fire,
  output logic linked,
  output logic phase_act,
  output logic asleep
);
  logic phase_q;
  logic asleep_q;

  assign linked    = link_en && act_on && inact_on;
  assign phase_act = phase_q;
  assign asleep    = asleep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      asleep_q <= 1'b0;
    end else begin
      if (!linked)         phase_q <= 1'b0;
      else if (inact_fire) phase_q <= 1'b1;
      else if (act_fire)   phase_q <= 1'b0;

      if (!(link_en && sleep_en)) asleep_q <= 1'b0;
      else if (act_fire)          asleep_q <= 1'b0;
      else if (inact_fire)        asleep_q <= 1'b1;
    end
  end

  AST_LINK_NO_INACT: assert property (@(posedge clk) disable iff (!rst_n)
    (linked && phase_q) |-> !inact_fire); // R8

  AST_LINK_NO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (linked && !phase_q) |-> !act_fire); // R8

  AST_SLEEP_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    asleep_q |-> $past(link_en && sleep_en)); // R9
endmodule

// File: rtl/motion_watch.sv
module motion_watch
  import motion_pkg::*;
#(
  parameter int unsigned SW  = SMP_W,
  parameter int unsigned TW  = THR_W,
  parameter int unsigned SH  = THR_SHIFT,
  parameter int unsigned TMW = TIME_W,
  parameter int unsigned NA  = AXES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_x,
  input  logic signed [SW-1:0] smp_y,
  input  logic signed [SW-1:0] smp_z,
  input  logic                 sec_tick,
  input  logic [TW-1:0]        act_thr,
  input  logic [TW-1:0]        inact_thr,
  input  logic [TMW-1:0]       inact_time,
  input  logic                 act_ac,
  input  logic                 inact_ac,
  input  logic [NA-1:0]        act_axis_en,
  input  logic [NA-1:0]        inact_axis_en,
  input  logic                 link_en,
  input  logic                 auto_sleep_en,
  output logic                 act_evt,
  output logic                 inact_evt,
  output logic [NA-1:0]        act_src,
  output logic                 asleep
);
  logic signed [SW-1:0] smp_arr [NA];
  logic [NA-1:0]        act_over;
  logic [NA-1:0]        inact_quiet;
  logic [NA-1:0]        act_hit;

  // Named internal events
  logic act_on, inact_on, linked, phase_act;
  logic act_armed, inact_armed;
  logic act_cap, inact_cap;
  logic inact_loud, quiet_smp, break_smp, timer_met;
  logic act_fire, inact_fire;

  logic          act_need_q, inact_need_q;
  logic          act_evt_q, inact_evt_q;
  logic [NA-1:0] act_src_q;

  always_comb begin
    for (int i = 0; i < int'(NA); i++) smp_arr[i] = '0;
    smp_arr[0] = smp_x;
    smp_arr[1] = smp_y;
    smp_arr[2] = smp_z;
  end

  for (genvar g = 0; g < NA; g++) begin : g_axis
    mw_axis_chan #(.SW(SW), .TW(TW), .SH(SH)) chan_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp        (smp_arr[g]),
      .act_cap    (act_cap),
      .inact_cap  (inact_cap),
      .act_ac     (act_ac),
      .inact_ac   (inact_ac),
      .act_thr    (act_thr),
      .inact_thr  (inact_thr),
      .act_over   (act_over[g]),
      .inact_quiet(inact_quiet[g])
    );
  end

  always_comb begin
    act_on      = |act_axis_en;
    inact_on    = |inact_axis_en;
    act_armed   = act_on && (!linked || phase_act);
    inact_armed = inact_on && (!linked || !phase_act);
    act_hit     = act_over & act_axis_en;
    act_fire    = smp_valid && act_armed && !(act_ac && act_need_q) && (|act_hit);
    act_cap     = smp_valid && act_need_q;
    inact_loud  = |(~inact_quiet & inact_axis_en);
    inact_cap   = smp_valid && (inact_need_q || inact_loud);
    quiet_smp   = smp_valid && inact_on && !inact_loud && !(inact_ac && inact_need_q);
    break_smp   = smp_valid && !quiet_smp;
    inact_fire  = inact_armed && timer_met;
  end

  mw_quiet_timer #(.TIME_W(TMW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .quiet_smp(quiet_smp),
    .break_smp(break_smp),
    .restart  (act_fire && linked),
    .tick     (sec_tick),
    .fire     (inact_fire),
    .time_lim (inact_time),
    .met      (timer_met)
  );

  mw_link_seq link_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_en   (link_en),
    .sleep_en  (auto_sleep_en),
    .act_on    (act_on),
    .inact_on  (inact_on),
    .act_fire  (act_fire),
    .inact_fire(inact_fire),
    .linked    (linked),
    .phase_act (phase_act),
    .asleep    (asleep)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_need_q   <= 1'b1;
      inact_need_q <= 1'b1;
      act_evt_q    <= 1'b0;
      inact_evt_q  <= 1'b0;
      act_src_q    <= '0;
    end else begin
      if (act_fire || (inact_fire && linked)) act_need_q <= 1'b1;
      else if (smp_valid)                     act_need_q <= 1'b0;
      if (act_fire && linked)                 inact_need_q <= 1'b1;
      else if (smp_valid)                     inact_need_q <= 1'b0;
      act_evt_q   <= act_fire;
      inact_evt_q <= inact_fire;
      if (act_fire) act_src_q <= act_hit;
    end
  end

  assign act_evt   = act_evt_q;
  assign inact_evt = inact_evt_q;
  assign act_src   = act_src_q;

  AST_EVT_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (act_evt || inact_evt) |-> $past(smp_valid)); // R3

  AST_ACT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    act_evt |-> $past(act_axis_en != '0)); // R3

  AST_INACT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    inact_evt |-> $past(inact_axis_en != '0)); // R5

  AST_AC_REF_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && act_ac && act_need_q) |=> !act_evt); // R2

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !act_evt |-> $stable(act_src)); // R4

  AST_SRC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    act_evt |-> (act_src != '0)); // R4

  AST_LINK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(linked) |-> !(act_evt && inact_evt)); // R8
endmodule

// File: tb/motion_watch_tb_top.sv
module motion_watch_tb_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_valid = 1'b0;
  logic signed [12:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic              sec_tick = 1'b0;
  logic [7:0]        act_thr = '0, inact_thr = '0, inact_time = '0;
  logic              act_ac = 1'b0, inact_ac = 1'b0;
  logic [2:0]        act_axis_en = '0, inact_axis_en = '0;
  logic              link_en = 1'b0, auto_sleep_en = 1'b0;
  logic              act_evt, inact_evt, asleep;
  logic [2:0]        act_src;

  int    n_chk = 0, n_fail = 0;
  bit    finished = 1'b0;
  string cur_req = "R11";

  // bench model state
  int       s_in[3];
  int       m_aref[3], m_iref[3];
  bit       m_aneed, m_ineed, m_run, m_done, m_phase, m_asleep;
  int       m_cnt;
  bit [2:0] m_src;
  bit       exp_act, exp_inact;

  always #4 clk = ~clk;

  motion_watch dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z), .sec_tick(sec_tick),
    .act_thr(act_thr), .inact_thr(inact_thr), .inact_time(inact_time),
    .act_ac(act_ac), .inact_ac(inact_ac),
    .act_axis_en(act_axis_en), .inact_axis_en(inact_axis_en),
    .link_en(link_en), .auto_sleep_en(auto_sleep_en),
    .act_evt(act_evt), .inact_evt(inact_evt), .act_src(act_src), .asleep(asleep)
  );

  function automatic int b_abs(input int v);
    if (v < 0) return -v;
    return v;
  endfunction

  task automatic chk(input string what, input string req, input int got, input int want);
    n_chk++;
    if (got != want) begin
      n_fail++;
      $display("FAIL %s (%s) %s: actual %0d expected %0d", req, cur_req, what, got, want);
    end
  endtask

  task automatic compare_all();
    chk("act_evt",   "R3", int'(act_evt),   int'(exp_act));
    chk("inact_evt", "R6", int'(inact_evt), int'(exp_inact));
    chk("asleep",    "R9", int'(asleep),    int'(m_asleep));
    chk("act_src",   "R4", int'(act_src),   int'(m_src));
  endtask

  task automatic model_reset();
    for (int a = 0; a < 3; a++) begin m_aref[a] = 0; m_iref[a] = 0; end
    m_aneed = 1; m_ineed = 1; m_run = 0; m_done = 0; m_phase = 0;
    m_asleep = 0; m_cnt = 0; m_src = 0; exp_act = 0; exp_inact = 0;
  endtask

  task automatic model_step();
    bit [2:0] hitv;
    bit loud, quiet, met, fire_a, fire_i, lnk, arm_a, arm_i, vld;
    vld  = smp_valid;
    lnk  = link_en && (act_axis_en != 0) && (inact_axis_en != 0);
    arm_a = (act_axis_en != 0) && (!lnk || m_phase);
    arm_i = (inact_axis_en != 0) && (!lnk || !m_phase);
    hitv = 0; loud = 0;
    for (int a = 0; a < 3; a++) begin
      int da, di;
      da = act_ac ? s_in[a] - m_aref[a] : s_in[a];
      di = inact_ac ? s_in[a] - m_iref[a] : s_in[a];
      if (act_axis_en[a] && b_abs(da) > int'(act_thr) * 16) hitv[a] = 1;
      if (inact_axis_en[a] && !(b_abs(di) < int'(inact_thr) * 16)) loud = 1;
    end
    fire_a = vld && arm_a && !(act_ac && m_aneed) && (hitv != 0);
    quiet  = vld && (inact_axis_en != 0) && !loud && !(inact_ac && m_ineed);
    met    = quiet && !m_done && (m_run ? (m_cnt >= int'(inact_time)) : (inact_time == 0));
    fire_i = arm_i && met;
    for (int a = 0; a < 3; a++) begin
      if (vld && m_aneed) m_aref[a] = s_in[a];
      if (vld && (m_ineed || loud)) m_iref[a] = s_in[a];
    end
    if ((fire_a && lnk) || (vld && !quiet)) begin
      m_run = 0; m_cnt = 0; m_done = 0;
    end else begin
      if (quiet && !m_run) begin m_run = 1; m_cnt = 0; end
      else if (m_run && sec_tick && m_cnt < 255) m_cnt++;
      if (fire_i) m_done = 1;
    end
    if (!lnk) m_phase = 0; else if (fire_i) m_phase = 1; else if (fire_a) m_phase = 0;
    if (!(link_en && auto_sleep_en)) m_asleep = 0;
    else if (fire_a) m_asleep = 0; else if (fire_i) m_asleep = 1;
    if (fire_a || (fire_i && lnk)) m_aneed = 1; else if (vld) m_aneed = 0;
    if (fire_a && lnk) m_ineed = 1; else if (vld) m_ineed = 0;
    if (fire_a) m_src = hitv;
    exp_act = fire_a; exp_inact = fire_i;
  endtask

  task automatic step(input bit v, input int x, input int y, input int z, input bit tk);
    smp_valid = v; sec_tick = tk;
    s_in[0] = x; s_in[1] = y; s_in[2] = z;
    smp_x = 13'(x); smp_y = 13'(y); smp_z = 13'(z);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic cfg(input bit aac, input bit iac, input bit [2:0] aen, input bit [2:0] ien,
                     input int athr, input int ithr, input int tm, input bit lk, input bit sl);
    act_ac = aac; inact_ac = iac; act_axis_en = aen; inact_axis_en = ien;
    act_thr = 8'(athr); inact_thr = 8'(ithr); inact_time = 8'(tm);
    link_en = lk; auto_sleep_en = sl;
  endtask

  initial begin
    void'($urandom(32'd20250611));
    model_reset();
    repeat (3) begin
      @(negedge clk);
      cur_req = "R11";
      compare_all();
    end
    rst_n = 1'b1;

    // R1: dc activity boundary on x only, threshold 2 -> 32
    cur_req = "R1";
    cfg(0, 0, 3'b001, 3'b000, 2, 2, 0, 0, 0);
    step(1, 32, 0, 0, 0);  step(1, 33, 0, 0, 0);
    step(1, -32, 0, 0, 0); step(1, -33, 0, 0, 0);
    step(0, 90, 0, 0, 0);  step(1, 0, 200, 0, 0);

    // R3 / R4: OR of enabled axes, source bits, all axes off
    cur_req = "R3";
    cfg(0, 0, 3'b110, 3'b000, 2, 2, 0, 0, 0);
    step(1, 0, 50, 0, 0); step(1, 200, 0, 0, 0); step(1, 0, 40, -40, 0);
    cur_req = "R4";
    step(1, 0, 0, 0, 0); step(1, 0, 0, 60, 0);
    cur_req = "R3";
    cfg(0, 0, 3'b000, 3'b000, 2, 2, 0, 0, 0);
    step(1, 300, 300, 300, 0);

    // R2: ac activity against captured reference
    cur_req = "R2";
    cfg(1, 0, 3'b111, 3'b000, 1, 2, 0, 0, 0);
    step(1, 100, 0, 0, 0); step(1, 100, 0, 0, 0); step(1, 116, 0, 0, 0);
    step(1, 117, 0, 0, 0); step(1, 117, 0, 0, 0); step(1, 90, 0, 0, 0);

    // R5 / R6: dc inactivity, timer and one event per run
    cur_req = "R6";
    cfg(0, 0, 3'b000, 3'b111, 2, 2, 2, 0, 0);
    step(1, 10, -10, 5, 0); step(0, 0, 0, 0, 1); step(1, 10, -10, 5, 0);
    step(0, 0, 0, 0, 1);    step(1, 31, -31, 0, 0); step(1, 0, 0, 0, 0);
    cur_req = "R5";
    step(1, 32, 0, 0, 0);
    inact_time = 8'd0;
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    inact_axis_en = 3'b000;
    step(1, 0, 0, 0, 0);

    // R7: ac inactivity reference reload
    cur_req = "R7";
    cfg(0, 1, 3'b000, 3'b111, 2, 1, 0, 0, 0);
    step(1, 200, 200, 200, 0); step(1, 205, 195, 200, 0);
    step(1, 300, 200, 200, 0); step(1, 310, 210, 190, 0);

    // R8 / R9: link mode alternation with auto-sleep
    cur_req = "R8";
    cfg(0, 0, 3'b111, 3'b111, 4, 2, 1, 1, 1);
    step(1, 200, 0, 0, 0); step(1, 0, 0, 0, 0); step(0, 0, 0, 0, 1);
    cur_req = "R9";
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 1);
    step(1, 0, 0, 100, 0); step(1, 0, 0, 0, 0);
    auto_sleep_en = 1'b0;
    step(1, 0, 0, 0, 0);

    // R10: concurrent operation with link clear
    cur_req = "R10";
    cfg(0, 0, 3'b111, 3'b111, 4, 5, 0, 0, 1);
    step(1, 70, 0, 0, 0); step(1, 10, 0, 0, 0); step(1, 70, 0, 0, 0);

    // Random mix across all modes
    for (int blk = 0; blk < 30; blk++) begin
      cur_req = (blk % 2 == 0) ? "R10" : "R8";
      cfg($urandom_range(0, 1), $urandom_range(0, 1), 3'($urandom_range(0, 7)),
          3'($urandom_range(0, 7)), $urandom_range(1, 6), $urandom_range(1, 6),
          $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1));
      for (int k = 0; k < 150; k++) begin
        int span;
        span = (k % 40 < 25) ? 40 : 160;
        step($urandom_range(0, 9) < 7,
             $urandom_range(0, 2 * span) - span, $urandom_range(0, 2 * span) - span,
             $urandom_range(0, 2 * span) - span, $urandom_range(0, 9) == 0);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R11 watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule